// File: doc/BRIEF.md
# Reset/Hold Pin Mode Controller

This block manages a single shared control pin on a serial-peripheral target. After power-up the pin acts as an active-low reset. Once the host sends a one-byte mode command, the pin becomes an active-low hold input and stays that way until the next power-on reset. In reset role, a low level that lasts long enough raises an internal reset. That reset aborts the current transfer and returns the status register and any auto-increment programming state to their power-up values. In hold role, the block pauses the serial transfer without losing its place. It gates off shifting and the data-out driver, ignores the serial clock, and keeps the bit position inside the current byte.

All pad inputs (serial clock, chip select, data-in and the shared pin) are oversampled by a fast system clock through a synchronizer chain. Hold entry and hold exit take effect only while the synchronized serial clock is low. An edge of the pin that arrives while the clock is high is therefore deferred to the next low phase. The block gives downstream logic a shift permission, a data-out enable, an internal reset and the current bit index.

Top module: `rst_hold_pin_ctrl`

## Requirements
- R1: While power-on reset is active, int_rst is 1, shift_en and dout_oe are 0 and bit_pos is 0. After the power-on reset the pin is in reset role, and power-on reset also returns an already switched pin to reset role.
- R2: With chip select low, the pin not pausing the transfer and no internal reset, shift_en and dout_oe are 1. bit_pos advances by one on each rising serial clock edge and wraps after OPC_BITS bits.
- R3: In reset role, int_rst rises only after the synchronized pin has been sampled low on RST_MIN_CYC consecutive system clocks, and falls on the cycle after the pin is sampled high. With RST_MIN_CYC = 8, a low pulse of 7 system clocks gives no internal reset, 8 clocks give one cycle of int_rst, and 20 clocks give 13 cycles.
- R4: While int_rst is 1, shift_en and dout_oe are 0, and the partial command is discarded: bit_pos returns to 0 and the bits received before the reset no longer count toward the mode command.
- R5: The pin switches to hold role when chip select rises after exactly OPC_BITS data bits have been shifted in MSB first, sampled on rising serial clock edges, and those bits equal HOLD_OPC (default 8'hAA). A different byte, or the right byte followed by further bits, leaves the role unchanged.
- R6: Hold role is sticky. No command and no level of the pin returns the pin to reset role, and in hold role a low pin never raises int_rst.
- R7: In hold role with chip select low, the transfer pauses when the pin is low while the serial clock is low. If the pin falls while the clock is high, the pause starts when the clock next goes low.
- R8: A pause ends when the pin is high while the serial clock is low. If the pin rises while the clock is high, the pause continues until the clock next goes low.
- R9: While paused, shift_en and dout_oe are 0 and rising serial clock edges are ignored, so bit_pos keeps its value and shifting resumes at the same bit.
- R10: Raising chip select during a pause ends the pause, returns to standby and clears bit_pos to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in, used to detect the mode command |
| rh_pin | input | 1 | Shared reset/hold pin, active low in both roles |
| shift_en | output | 1 | Permission for the serial shifter to take bits |
| dout_oe | output | 1 | Permission for the data-out driver to drive |
| int_rst | output | 1 | Internal reset for status and programming state |
| bit_pos | output | $clog2(OPC_BITS) | Bit index within the current byte |

## Verification
The assertions check on every cycle that the pin role never falls back, that a pause starts or ends only on a cycle that saw the serial clock low, and that a pause exists only while chip select was low in hold role. They also check that the bit index stays frozen across a pause, that the index is cleared after an internal reset, that the reset releases promptly, and that the command flag is armed only at a byte boundary. Only the bench scenarios can show the exact glitch-filter thresholds, that the mode command is recognised under its exact-length rule and rejected otherwise, and the deferred entry and exit sequences as a host would drive them. The same holds for the return to reset role after a later power-on reset.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

  typedef enum logic {
    HS_RUN    = 1'b0,
    HS_PAUSED = 1'b1
  } hold_st_e;

  // Oversampled pad bundle
  typedef struct packed {
    logic sdi;
    logic pin;
    logic cs_n;
    logic sck;
  } pad_t;

  localparam pad_t PAD_IDLE = '{sdi: 1'b0, pin: 1'b1, cs_n: 1'b1, sck: 1'b0};

endpackage

// File: rtl/rhp_sync.sv
module rhp_sync #(
  parameter int unsigned          W       = 4,
  parameter int unsigned          STAGES  = 2,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {NS{RST_VAL}};
    else        stg_q <= {stg_q[NS-2:0], d};
  end

  assign q = stg_q[NS-1];

endmodule

// File: rtl/rhp_rst_filter.sv
module rhp_rst_filter #(
  parameter int unsigned MIN_LOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_role,
  input  logic pin_s,
  output logic rst_o
);

  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;

  always_comb begin
    if (hold_role || pin_s)  cnt_d = '0;
    else if (cnt_q == CMAX)  cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
    rst_d = (cnt_d == CMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign rst_o = rst_q;

  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q && pin_s |=> !rst_q); // R3

  AST_NO_RST_IN_HOLD_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_role && $past(hold_role) |-> !rst_q); // R6

endmodule

// File: rtl/rhp_hold_fsm.sv
module rhp_hold_fsm
  import rhp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_role,
  input  logic cs_s,
  input  logic sck_s,
  input  logic pin_s,
  output logic held_o
);

  hold_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_RUN:
        if (hold_role && !cs_s && !pin_s && !sck_s) st_d = HS_PAUSED;
      HS_PAUSED:
        if (cs_s || !hold_role)   st_d = HS_RUN;
        else if (pin_s && !sck_s) st_d = HS_RUN;
      default: st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_RUN;
    else        st_q <= st_d;
  end

  assign held_o = (st_q == HS_PAUSED);

  AST_HOLD_ENTRY_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> $past(!sck_s)); // R7

  AST_HOLD_EXIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_o) && $past(!cs_s) |-> $past(!sck_s)); // R8

  AST_HOLD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    held_o |-> $past(!cs_s) && $past(hold_role)); // R10

endmodule

// File: rtl/rhp_cmd_track.sv
module rhp_cmd_track #(
  parameter int unsigned          OPC_BITS = 8,
  parameter logic [OPC_BITS-1:0]  ROLE_OPC = 8'hAA,
  localparam int unsigned         BW       = $clog2(OPC_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          freeze,
  input  logic          abort,
  output logic [BW-1:0] bit_pos,
  output logic          role_hit
);

  localparam logic [BW-1:0] LAST = BW'(OPC_BITS - 1);

  logic                sck_prev_q;
  logic [OPC_BITS-1:0] sh_q, sh_d;
  logic [BW-1:0]       bit_q, bit_d;
  logic                first_q, first_d;
  logic                armed_q, armed_d;
  logic                rise;

  assign rise = sck_s & ~sck_prev_q;

  always_comb begin
    sh_d    = sh_q;
    bit_d   = bit_q;
    first_d = first_q;
    armed_d = armed_q;
    if (cs_s || abort) begin
      sh_d    = '0;
      bit_d   = '0;
      first_d = 1'b0;
      armed_d = 1'b0;
    end else if (rise && !freeze) begin
      sh_d  = {sh_q[OPC_BITS-2:0], sdi_s};
      bit_d = (bit_q == LAST) ? '0 : bit_q + 1'b1;
      if (bit_q == LAST && !first_q) begin
        first_d = 1'b1;
        armed_d = (sh_d == ROLE_OPC);
      end else begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      sh_q       <= '0;
      bit_q      <= '0;
      first_q    <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      sh_q       <= sh_d;
      bit_q      <= bit_d;
      first_q    <= first_d;
      armed_q    <= armed_d;
    end
  end

  assign bit_pos  = bit_q;
  assign role_hit = cs_s & armed_q;

  AST_POS_KEPT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && !cs_s && !abort |=> $stable(bit_q)); // R9

  AST_ARM_AT_BYTE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> first_q && (bit_q == '0)); // R5

endmodule

// File: rtl/rst_hold_pin_ctrl.sv
module rst_hold_pin_ctrl
  import rhp_pkg::*;
#(
  parameter int unsigned          SYNC_STAGES = 2,
  parameter int unsigned          RST_MIN_CYC = 8,
  parameter int unsigned          OPC_BITS    = 8,
  parameter logic [OPC_BITS-1:0]  HOLD_OPC    = 8'hAA,
  localparam int unsigned         BW          = $clog2(OPC_BITS)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic          rh_pin,
  output logic          shift_en,
  output logic          dout_oe,
  output logic          int_rst,
  output logic [BW-1:0] bit_pos
);

  localparam int unsigned PW = $bits(pad_t);

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  pad_t pad_raw, pad_s;
  assign pad_raw = '{sdi: sdi, pin: rh_pin, cs_n: cs_n, sck: sck};

  rhp_sync #(
    .W      (PW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PW'(PAD_IDLE))
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_raw),
    .q    (pad_s)
  );

  // pin role: 0 = reset, 1 = hold; cleared only by power-on reset
  logic role_q, role_d;
  logic role_hit, held, rst_q;

  always_comb role_d = role_q | role_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) role_q <= 1'b0;
    else        role_q <= role_d;
  end

  rhp_rst_filter #(.MIN_LOW(RST_MIN_CYC)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_role(role_q),
    .pin_s    (pad_s.pin),
    .rst_o    (rst_q)
  );

  rhp_hold_fsm u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_role(role_q),
    .cs_s     (pad_s.cs_n),
    .sck_s    (pad_s.sck),
    .pin_s    (pad_s.pin),
    .held_o   (held)
  );

  rhp_cmd_track #(
    .OPC_BITS(OPC_BITS),
    .ROLE_OPC(HOLD_OPC)
  ) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (pad_s.cs_n),
    .sck_s   (pad_s.sck),
    .sdi_s   (pad_s.sdi),
    .freeze  (held),
    .abort   (rst_q),
    .bit_pos (bit_pos),
    .role_hit(role_hit)
  );

  assign shift_en = ~pad_s.cs_n & ~held & ~rst_q;
  assign dout_oe  = ~pad_s.cs_n & ~held & ~rst_q;
  assign int_rst  = rst_q;

  AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    role_q |=> role_q); // R6

  AST_RST_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> bit_pos == '0); // R4

endmodule

// File: tb/sim_rst_hold_pin_ctrl.sv
module sim_rst_hold_pin_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 8;

  logic       clk = 1'b0;
  logic       por_n, sck, cs_n, sdi, rh_pin;
  logic       shift_en, dout_oe, int_rst;
  logic [2:0] bit_pos;

  int n_cmp = 0;
  int n_bad = 0;
  int rst_hits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_hold_pin_ctrl #(.RST_MIN_CYC(MIN_LOW)) u0 (
    .clk(clk), .por_n(por_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .rh_pin(rh_pin),
    .shift_en(shift_en), .dout_oe(dout_oe), .int_rst(int_rst), .bit_pos(bit_pos)
  );

  always @(negedge clk) if (int_rst === 1'b1) rst_hits++;

  // hold-role walk: {cs_n, sck, pin, exp_shift_en, exp_dout_oe, exp_bit_pos[2:0]}
  localparam int NROW = 12;
  localparam logic [7:0] TBL [NROW] = '{
    8'b0_0_1_1_1_000,  // selected, running (R2)
    8'b0_1_1_1_1_001,  // rising edge counted (R2)
    8'b0_1_0_1_1_001,  // pin falls with clock high: no pause yet (R7)
    8'b0_0_0_0_0_001,  // clock low: pause begins (R7)
    8'b0_1_0_0_0_001,  // edge during pause ignored, index kept (R9)
    8'b0_1_1_0_0_001,  // pin rises with clock high: still paused (R8)
    8'b0_0_1_1_1_001,  // clock low: pause ends (R8)
    8'b0_0_0_0_0_001,  // coincident entry (R7)
    8'b0_0_1_1_1_001,  // coincident exit (R8)
    8'b0_0_0_0_0_001,  // paused again (R7)
    8'b1_0_0_0_0_000,  // deselect ends pause, index cleared (R10)
    8'b1_0_1_0_0_000   // idle, low pin raised no reset (R6)
  };

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wt(4);
    sck = 1'b1; wt(4);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // pin low for exactly n sampling edges, returns cycles int_rst was high
  task automatic pin_pulse(input int n, output int hits);
    int base;
    @(posedge clk); #1;
    base = rst_hits;
    rh_pin = 1'b0;
    repeat (n) @(posedge clk);
    #1 rh_pin = 1'b1;
    wt(8);
    hits = rst_hits - base;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hits;
    por_n = 1'b0; sck = 1'b0; cs_n = 1'b1; sdi = 1'b0; rh_pin = 1'b1;
    wt(3);
    @(negedge clk);
    check("R1 int_rst in por", int_rst, 1);
    check("R1 shift_en in por", shift_en, 0);
    check("R1 dout_oe in por", dout_oe, 0);
    check("R1 bit_pos in por", bit_pos, 0);
    wt(1); por_n = 1'b1; wt(10);
    @(negedge clk);
    check("R1 int_rst released", int_rst, 0);

    // R2 select and count
    wt(1); cs_n = 1'b0; wt(6);
    @(negedge clk);
    check("R2 shift_en selected", shift_en, 1);
    check("R2 dout_oe selected", dout_oe, 1);
    wt(1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    wt(6);
    @(negedge clk);
    check("R2 bit_pos after 3 bits", bit_pos, 3);

    // R4 reset mid-command
    wt(1); rh_pin = 1'b0; wt(14);
    @(negedge clk);
    check("R4 int_rst asserted", int_rst, 1);
    check("R4 shift_en gated", shift_en, 0);
    check("R4 dout_oe gated", dout_oe, 0);
    wt(1); rh_pin = 1'b1; wt(6);
    @(negedge clk);
    check("R4 bit_pos cleared", bit_pos, 0);
    check("R4 shift_en back", shift_en, 1);
    wt(1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    wt(6);
    @(negedge clk);
    check("R4 bit_pos restarted", bit_pos, 5);
    wt(1); cs_n = 1'b1; wt(6);
    pin_pulse(20, hits);
    check("R3 long pulse width / R4 split opcode ignored", hits, 13);

    // R3 glitch boundary
    pin_pulse(MIN_LOW - 1, hits);
    check("R3 short glitch rejected", hits, 0);
    pin_pulse(MIN_LOW, hits);
    check("R3 minimum pulse accepted", hits, 1);

    // R5 wrong byte
    wt(1); cs_n = 1'b0; wt(4);
    send_byte(8'hAB);
    wt(2); cs_n = 1'b1; wt(6);
    pin_pulse(12, hits);
    check("R5 other opcode keeps reset role", hits, 5);

    // R5 right byte plus one bit
    wt(1); cs_n = 1'b0; wt(4);
    send_byte(8'hAA); send_bit(1'b0);
    wt(6);
    @(negedge clk);
    check("R5 ninth bit wraps index", bit_pos, 1);
    wt(1); cs_n = 1'b1; wt(6);
    pin_pulse(12, hits);
    check("R5 overlong command keeps reset role", hits, 5);

    // R5 exact command
    wt(1); cs_n = 1'b0; wt(4);
    send_byte(8'hAA);
    wt(2); cs_n = 1'b1; wt(6);
    pin_pulse(12, hits);
    check("R5 R6 hold role: no reset", hits, 0);

    // hold-role table
    for (int r = 0; r < NROW; r++) begin
      int base;
      wt(1);
      base = rst_hits;
      cs_n = TBL[r][7]; sck = TBL[r][6]; rh_pin = TBL[r][5];
      wt(6);
      @(negedge clk);
      check($sformatf("R7 R8 R9 R10 row %0d shift_en", r), shift_en, TBL[r][4]);
      check($sformatf("R7 R8 R9 R10 row %0d dout_oe", r), dout_oe, TBL[r][3]);
      check($sformatf("R9 R10 row %0d bit_pos", r), bit_pos, TBL[r][2:0]);
      check($sformatf("R6 row %0d no reset", r), rst_hits - base, 0);
    end

    // R1 power-on reset restores reset role
    wt(1); por_n = 1'b0; wt(3); por_n = 1'b1; wt(10);
    pin_pulse(12, hits);
    check("R1 por restores reset role", hits, 5);

    finish_run();
  end

endmodule